// File: doc/BRIEF.md
# Four-Way Unified Cache

A unified instruction and data cache placed between a 32-bit processor bus and main memory. Storage is organised as 64 sets of four ways, each line holding four 32-bit words (16 bytes). Every set carries a six-bit age record that orders its four ways by recency. The record names the replacement victim once the set has no free way left.

The processor side uses a request/ready handshake. The request holds address, write data, byte enables and direction until a one-cycle ready pulse completes it. The memory side fetches a line as a four-beat burst that starts at word 0 and writes a modified line back as a four-beat burst. A single-beat write with byte enables serves write-through stores. A mode input selects write-back or write-through; it is changed only while the cache is idle. A global invalidate input sweeps all sets in 64 cycles. It drops all lines, including modified ones, without writing them to memory.

Top module: `ucache_top`

## Requirements
- R1: A read hit raises `ready_o` in the cycle after the request is accepted, with the addressed word on `rdata_o`, and causes no memory traffic.
- R2: A read miss fetches the line as a four-beat burst (`mem_burst_o`=1), with word addresses base+0, +4, +8, +12 in that order, then returns the requested word.
- R3: Address bits [31:10] form the tag, [9:4] the set and [3:2] the word within the line; four distinct tags that map to one set are resident at once.
- R4: A miss fills the lowest-numbered invalid way of its set before any valid way is replaced.
- R5: Each hit or fill makes the accessed way the most recent of its set; with all four ways valid, the victim is the way older than the other three.
- R6: In write-back mode a write hit merges the enabled bytes (`be_i` bit n covers data bits 8n+7..8n) into the line and causes no memory write.
- R7: In write-back mode a write miss first fetches the line, then merges the write into it and marks it modified.
- R8: A modified victim is written to memory as a four-beat burst in word order before the refill; a clean victim produces no memory write.
- R9: In write-through mode every write issues one single-beat memory write (`mem_burst_o`=0) with the request's byte enables; a write hit also updates the line.
- R10: In write-through mode a write miss allocates no line, so a following read of that line misses.
- R11: In write-through mode no line becomes modified, so evicting it produces no memory write.
- R12: An invalidate pulse while idle keeps `ready_o` low and issues no memory traffic for 64 cycles. It leaves every line invalid and discards modified data without writing it back.
- R13: After reset `ready_o` and `mem_req_o` are low and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_mode_i | input | 1 | 1 = write-back, 0 = write-through |
| inv_i | input | 1 | Global invalidate request, sampled while idle |
| req_i | input | 1 | Processor request valid |
| we_i | input | 1 | Request is a write |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte enables for writes |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Read data, valid with ready_o |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | Memory beat is a write |
| mem_burst_o | output | 1 | Beat belongs to a four-beat line transfer |
| mem_addr_o | output | 32 | Byte address of the current beat |
| mem_wdata_o | output | 32 | Memory write data |
| mem_be_o | output | 4 | Memory byte enables |
| mem_ready_i | input | 1 | Memory accepts or returns the current beat |
| mem_rdata_i | input | 32 | Memory read data |

## Verification
Victim write-back and line refill fall within the same miss. A modified line must leave before its slot is reused, so the bench dirties a line in write-back mode and fills the other three ways of its set. It then forces a fifth tag into the set and counts four write beats followed by four read beats. The memory image is compared with the merged data. LRU ordering and the hit path meet on the same access as well. Re-reading the surviving tags must return data in one cycle with zero beats, while the displaced tag must miss.

// File: rtl/ucache_pkg.sv
package ucache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_EVICT,
    ST_REFILL,
    ST_WTWRITE,
    ST_INV
  } cache_state_e;
endpackage

// File: rtl/ucache_lru.sv
module ucache_lru #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned WAY_W = 2,
  parameter int unsigned NPAIR = 6
) (
  input  logic [NPAIR-1:0] age_i,
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAY_W-1:0] touch_i,
  output logic [NPAIR-1:0] age_o,
  output logic [WAYS-1:0]  older_o,
  output logic [WAY_W-1:0] victim_o
);
  // pair (i,j), i<j: bit set means way i used more recently than way j
  function automatic int unsigned pidx(int unsigned i, int unsigned j);
    return i * WAYS - (i * (i + 1)) / 2 + (j - i - 1);
  endfunction

  always_comb begin
    age_o = age_i;
    for (int unsigned i = 0; i < WAYS; i++) begin
      for (int unsigned j = i + 1; j < WAYS; j++) begin
        if (touch_i == WAY_W'(i))      age_o[pidx(i, j)] = 1'b1;
        else if (touch_i == WAY_W'(j)) age_o[pidx(i, j)] = 1'b0;
      end
    end
  end

  always_comb begin
    for (int unsigned v = 0; v < WAYS; v++) begin
      older_o[v] = 1'b1;
      for (int unsigned j = 0; j < WAYS; j++) begin
        if (j > v && age_i[pidx(v, j)])  older_o[v] = 1'b0;
        if (j < v && !age_i[pidx(j, v)]) older_o[v] = 1'b0;
      end
    end
  end

  always_comb begin
    victim_o = '0;
    if (&valid_i) begin
      for (int v = WAYS - 1; v >= 0; v--)
        if (older_o[v]) victim_o = WAY_W'(v);
    end else begin
      for (int v = WAYS - 1; v >= 0; v--)
        if (!valid_i[v]) victim_o = WAY_W'(v);
    end
  end
endmodule

// File: rtl/ucache_tag_ram.sv
module ucache_tag_ram #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned SETS  = 64,
  parameter int unsigned TAG_W = 22,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned WAY_W = 2,
  parameter int unsigned NPAIR = 6
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [IDX_W-1:0]                set_i,
  input  logic [TAG_W-1:0]                tag_i,
  output logic [WAYS-1:0]                 hit_o,
  output logic [WAYS-1:0]                 valid_o,
  output logic [WAYS-1:0]                 dirty_o,
  output logic [WAYS-1:0][TAG_W-1:0]      tag_way_o,
  output logic [NPAIR-1:0]                lru_o,
  input  logic                            clr_i,
  input  logic                            fill_i,
  input  logic [WAY_W-1:0]                fill_way_i,
  input  logic                            dirty_set_i,
  input  logic [WAY_W-1:0]                dirty_way_i,
  input  logic                            lru_we_i,
  input  logic [NPAIR-1:0]                lru_d_i
);
  logic [TAG_W-1:0]            tag_q [SETS][WAYS];
  logic [SETS-1:0][WAYS-1:0]   valid_q;
  logic [SETS-1:0][WAYS-1:0]   dirty_q;
  logic [SETS-1:0][NPAIR-1:0]  lru_q;

  assign valid_o = valid_q[set_i];
  assign dirty_o = dirty_q[set_i];
  assign lru_o   = lru_q[set_i];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign tag_way_o[w] = tag_q[set_i][w];
    assign hit_o[w]     = valid_q[set_i][w] && (tag_q[set_i][w] == tag_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
      lru_q   <= '0;
    end else if (clr_i) begin
      valid_q[set_i] <= '0;
      dirty_q[set_i] <= '0;
      lru_q[set_i]   <= '0;
    end else begin
      if (fill_i) begin
        valid_q[set_i][fill_way_i] <= 1'b1;
        dirty_q[set_i][fill_way_i] <= 1'b0;
      end
      if (dirty_set_i) dirty_q[set_i][dirty_way_i] <= 1'b1;
      if (lru_we_i)    lru_q[set_i] <= lru_d_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) tag_q[set_i][fill_way_i] <= tag_i;
  end

  // R12
  inv_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_i == IDX_W'(SETS - 1)) |=> (valid_q == '0 && dirty_q == '0));

  // R4
  fill_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !(&valid_o)) |-> !valid_o[fill_way_i]);
endmodule

// File: rtl/ucache_data_ram.sv
module ucache_data_ram #(
  parameter int unsigned WAYS       = 4,
  parameter int unsigned SETS       = 64,
  parameter int unsigned LINE_WORDS = 4,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned IDX_W      = 6,
  parameter int unsigned WAY_W      = 2,
  parameter int unsigned WORD_W     = 2,
  parameter int unsigned BE_W       = 4
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  set_i,
  input  logic [WAY_W-1:0]  rd_way_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              we_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i
);
  logic [DATA_W-1:0] line_q [SETS][WAYS][LINE_WORDS];

  assign rdata_o = line_q[set_i][rd_way_i][rd_word_i];

  for (genvar b = 0; b < BE_W; b++) begin : g_byte
    always_ff @(posedge clk_i) begin
      if (we_i && be_i[b]) line_q[set_i][wr_way_i][wr_word_i][8*b +: 8] <= wdata_i[8*b +: 8];
    end
  end
endmodule

// File: rtl/ucache_top.sv
module ucache_top #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned WAYS       = 4,
  parameter int unsigned SETS       = 64,
  parameter int unsigned LINE_WORDS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wb_mode_i,
  input  logic              inv_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W/8-1:0] be_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_burst_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [DATA_W/8-1:0] mem_be_o,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  import ucache_pkg::*;

  localparam int unsigned BE_W     = DATA_W / 8;
  localparam int unsigned BYTE_OFF = $clog2(BE_W);
  localparam int unsigned WORD_W   = $clog2(LINE_WORDS);
  localparam int unsigned OFF_W    = BYTE_OFF + WORD_W;
  localparam int unsigned IDX_W    = $clog2(SETS);
  localparam int unsigned TAG_W    = ADDR_W - IDX_W - OFF_W;
  localparam int unsigned WAY_W    = $clog2(WAYS);
  localparam int unsigned NPAIR    = WAYS * (WAYS - 1) / 2;

  cache_state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [BE_W-1:0]   be_q;
  logic              we_q;
  logic [WORD_W-1:0] beat_q, beat_d;
  logic [IDX_W-1:0]  inv_cnt_q, inv_cnt_d;
  logic [WAY_W-1:0]  victim_q, victim_d;

  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_set, set_sel;
  logic [WORD_W-1:0] a_word;
  assign a_tag  = addr_q[ADDR_W-1 -: TAG_W];
  assign a_set  = addr_q[OFF_W +: IDX_W];
  assign a_word = addr_q[BYTE_OFF +: WORD_W];
  assign set_sel = (state_q == ST_INV) ? inv_cnt_q : a_set;

  logic [WAYS-1:0]            hit_vec, valid_w, dirty_w, older_w;
  logic [WAYS-1:0][TAG_W-1:0] tag_way;
  logic [NPAIR-1:0]           lru_cur, lru_next;
  logic [WAY_W-1:0]           hit_way, lru_victim;
  logic                       hit;
  logic                       clr, fill, dset, lru_we, dwe;
  logic [WAY_W-1:0]           rd_way, wr_way;
  logic [WORD_W-1:0]          rd_word, wr_word;
  logic [BE_W-1:0]            dbe;
  logic [DATA_W-1:0]          dwdata, line_word;

  assign hit = |hit_vec;
  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  ucache_tag_ram #(
    .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .IDX_W(IDX_W), .WAY_W(WAY_W), .NPAIR(NPAIR)
  ) tags_i (
    .clk_i, .rst_ni,
    .set_i(set_sel), .tag_i(a_tag),
    .hit_o(hit_vec), .valid_o(valid_w), .dirty_o(dirty_w), .tag_way_o(tag_way), .lru_o(lru_cur),
    .clr_i(clr), .fill_i(fill), .fill_way_i(victim_q),
    .dirty_set_i(dset), .dirty_way_i(hit_way),
    .lru_we_i(lru_we), .lru_d_i(lru_next)
  );

  ucache_lru #(.WAYS(WAYS), .WAY_W(WAY_W), .NPAIR(NPAIR)) lru_i (
    .age_i(lru_cur), .valid_i(valid_w), .touch_i(hit_way),
    .age_o(lru_next), .older_o(older_w), .victim_o(lru_victim)
  );

  ucache_data_ram #(
    .WAYS(WAYS), .SETS(SETS), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W),
    .IDX_W(IDX_W), .WAY_W(WAY_W), .WORD_W(WORD_W), .BE_W(BE_W)
  ) data_i (
    .clk_i,
    .set_i(a_set), .rd_way_i(rd_way), .rd_word_i(rd_word), .rdata_o(line_word),
    .we_i(dwe), .wr_way_i(wr_way), .wr_word_i(wr_word), .be_i(dbe), .wdata_i(dwdata)
  );

  assign rd_way  = (state_q == ST_LOOKUP) ? hit_way : victim_q;
  assign rd_word = (state_q == ST_EVICT) ? beat_q : a_word;
  assign wr_way  = (state_q == ST_REFILL) ? victim_q : hit_way;
  assign wr_word = (state_q == ST_REFILL) ? beat_q : a_word;
  assign dbe     = (state_q == ST_REFILL) ? {BE_W{1'b1}} : be_q;
  assign dwdata  = (state_q == ST_REFILL) ? mem_rdata_i : wdata_q;
  assign rdata_o = line_word;

  always_comb begin
    state_d     = state_q;
    beat_d      = beat_q;
    inv_cnt_d   = inv_cnt_q;
    victim_d    = victim_q;
    ready_o     = 1'b0;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_burst_o = 1'b0;
    mem_addr_o  = {a_tag, a_set, beat_q, {BYTE_OFF{1'b0}}};
    mem_wdata_o = line_word;
    mem_be_o    = {BE_W{1'b1}};
    clr = 1'b0; fill = 1'b0; dset = 1'b0; lru_we = 1'b0; dwe = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (inv_i) begin
          state_d   = ST_INV;
          inv_cnt_d = '0;
        end else if (req_i) begin
          state_d = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (hit) begin
          lru_we = 1'b1;
          dwe    = we_q;
          if (we_q && !wb_mode_i) begin
            state_d = ST_WTWRITE;
          end else begin
            dset    = we_q;
            ready_o = 1'b1;
            state_d = ST_IDLE;
          end
        end else if (we_q && !wb_mode_i) begin
          state_d = ST_WTWRITE;
        end else begin
          victim_d = lru_victim;
          beat_d   = '0;
          state_d  = (valid_w[lru_victim] && dirty_w[lru_victim]) ? ST_EVICT : ST_REFILL;
        end
      end
      ST_EVICT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_burst_o = 1'b1;
        mem_addr_o  = {tag_way[victim_q], a_set, beat_q, {BYTE_OFF{1'b0}}};
        if (mem_ready_i) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == WORD_W'(LINE_WORDS - 1)) state_d = ST_REFILL;
        end
      end
      ST_REFILL: begin
        mem_req_o   = 1'b1;
        mem_burst_o = 1'b1;
        if (mem_ready_i) begin
          dwe    = 1'b1;
          beat_d = beat_q + 1'b1;
          if (beat_q == WORD_W'(LINE_WORDS - 1)) begin
            fill    = 1'b1;
            state_d = ST_LOOKUP;
          end
        end
      end
      ST_WTWRITE: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = {addr_q[ADDR_W-1:BYTE_OFF], {BYTE_OFF{1'b0}}};
        mem_wdata_o = wdata_q;
        mem_be_o    = be_q;
        if (mem_ready_i) begin
          ready_o = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_INV: begin
        clr       = 1'b1;
        inv_cnt_d = inv_cnt_q + 1'b1;
        if (inv_cnt_q == IDX_W'(SETS - 1)) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      beat_q    <= '0;
      inv_cnt_q <= '0;
      victim_q  <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      be_q      <= '0;
      we_q      <= 1'b0;
    end else begin
      state_q   <= state_d;
      beat_q    <= beat_d;
      inv_cnt_q <= inv_cnt_d;
      victim_q  <= victim_d;
      if (state_q == ST_IDLE && req_i && !inv_i) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        be_q    <= be_i;
        we_q    <= we_i;
      end
    end
  end

  // R1
  hit_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOOKUP && hit && !we_q) |-> (ready_o && !mem_req_o));

  // R2
  refill_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REFILL && mem_ready_i && beat_q == WORD_W'(LINE_WORDS - 1))
      |=> (state_q == ST_LOOKUP && hit));

  // R5
  lru_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOOKUP && (&valid_w)) |-> $onehot(older_w));

  // R10
  wt_noalloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WTWRITE) |=> $stable(valid_w));

  // R11
  wt_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOOKUP && we_q && !wb_mode_i) |=> $stable(dirty_w));

  // R12
  inv_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_INV) |-> (!ready_o && !mem_req_o));
endmodule

// File: tb/ucache_top_tb.sv
`timescale 1ns/1ps
module ucache_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wb_mode = 1'b1;
  logic        inv = 1'b0;
  logic        req = 1'b0;
  logic        we_r = 1'b0;
  logic [31:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  be_r = '0;
  logic        ready_o, mem_req_o, mem_we_o, mem_burst_o;
  logic [31:0] rdata_o, mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic [3:0]  mem_be_o;
  logic        mem_ready_i;
  logic        tog = 1'b0;

  logic [31:0] bmem   [4096];
  logic [31:0] gold_m [4096];
  int checks = 0, fails = 0;
  int rd_beats = 0, wr_beats = 0, rseq = 0, wseq = 0;

  always #2 clk = ~clk;
  always @(posedge clk) tog <= ~tog;
  assign mem_ready_i = mem_req_o & tog;
  assign mem_rdata_i = bmem[mem_addr_o[13:2]];

  ucache_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wb_mode_i(wb_mode), .inv_i(inv),
    .req_i(req), .we_i(we_r), .addr_i(addr), .wdata_i(wdata), .be_i(be_r),
    .ready_o, .rdata_o,
    .mem_req_o, .mem_we_o, .mem_burst_o, .mem_addr_o, .mem_wdata_o, .mem_be_o,
    .mem_ready_i, .mem_rdata_i
  );

  task automatic chk(input bit ok, input string r, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic logic [31:0] mk(int t, int s, int w);
    return 32'((t << 10) | (s << 4) | (w << 2));
  endfunction

  // memory model and beat monitor
  always @(negedge clk) begin
    if (rst_n && mem_req_o && mem_ready_i) begin
      if (mem_we_o) begin
        wr_beats++;
        for (int b = 0; b < 4; b++)
          if (mem_be_o[b]) bmem[mem_addr_o[13:2]][8*b +: 8] = mem_wdata_o[8*b +: 8];
        if (!wb_mode) chk(!mem_burst_o, "R9", "single-beat write", 32'(mem_burst_o), 0);
        if (mem_burst_o) begin
          chk(mem_addr_o[3:0] == {wseq[1:0], 2'b00}, "R8", "writeback beat order",
              mem_addr_o, {mem_addr_o[31:4], wseq[1:0], 2'b00});
          wseq++;
        end
      end else begin
        rd_beats++;
        chk(mem_burst_o && mem_addr_o[3:0] == {rseq[1:0], 2'b00}, "R2", "refill beat order",
            mem_addr_o, {mem_addr_o[31:4], rseq[1:0], 2'b00});
        rseq++;
      end
    end
  end

  task automatic access(input bit w, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be, output logic [31:0] rd, output int lat,
                        output int drd, output int dwr);
    int r0, w0;
    r0 = rd_beats; w0 = wr_beats;
    @(negedge clk);
    req = 1'b1; we_r = w; addr = a; wdata = d; be_r = be;
    lat = 0; rd = '0;
    forever begin
      @(negedge clk);
      lat++;
      if (ready_o) begin rd = rdata_o; break; end
      if (lat > 2000) begin chk(1'b0, "R1", "request timeout", 32'(lat), 0); break; end
    end
    @(negedge clk);
    req = 1'b0;
    if (w) for (int b = 0; b < 4; b++)
      if (be[b]) gold_m[a[13:2]][8*b +: 8] = d[8*b +: 8];
    drd = rd_beats - r0;
    dwr = wr_beats - w0;
  endtask

  task automatic rd_op(input logic [31:0] a, input int erd, input int ewr,
                       input string r, output int lat);
    logic [31:0] rd;
    int drd, dwr;
    access(1'b0, a, '0, 4'h0, rd, lat, drd, dwr);
    chk(rd == gold_m[a[13:2]], r, "read data", rd, gold_m[a[13:2]]);
    if (erd >= 0) chk(drd == erd, r, "read beats", 32'(drd), 32'(erd));
    if (ewr >= 0) chk(dwr == ewr, r, "write beats", 32'(dwr), 32'(ewr));
  endtask

  task automatic wr_op(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                       input int erd, input int ewr, input string r);
    logic [31:0] rd;
    int lat, drd, dwr;
    access(1'b1, a, d, be, rd, lat, drd, dwr);
    chk(drd == erd, r, "read beats", 32'(drd), 32'(erd));
    chk(dwr == ewr, r, "write beats", 32'(dwr), 32'(ewr));
  endtask

  task automatic do_inv();
    @(negedge clk); inv = 1'b1;
    @(negedge clk); inv = 1'b0;
    repeat (70) @(negedge clk);
    for (int i = 0; i < 4096; i++) gold_m[i] = bmem[i];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 0);
    finish_run();
  end

  initial begin
    int lat;
    logic [31:0] a, old;
    for (int i = 0; i < 4096; i++) begin
      bmem[i]   = 32'(i) * 32'h9E3779B1 + 32'h0123_4567;
      gold_m[i] = bmem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk(!ready_o && !mem_req_o, "R13", "idle after reset", {30'd0, ready_o, mem_req_o}, 0);

    // R3 R4 sweep: five tags per set, fifth displaces the oldest
    wb_mode = 1'b1;
    for (int t = 0; t < 5; t++)
      for (int s = 0; s < 64; s++) rd_op(mk(t, s, (s + t) % 4), 4, 0, "R3", lat);
    for (int t = 1; t < 5; t++)
      for (int s = 0; s < 64; s++) begin
        rd_op(mk(t, s, s % 4), 0, 0, "R5", lat);
        chk(lat == 1, "R1", "hit latency", 32'(lat), 1);
      end
    for (int s = 0; s < 64; s += 9) rd_op(mk(0, s, 1), 4, 0, "R5", lat);

    // R5 directed LRU order in set 5
    do_inv();
    for (int t = 0; t < 4; t++) rd_op(mk(t, 5, 0), 4, 0, "R4", lat);
    rd_op(mk(0, 5, 2), 0, 0, "R5", lat);
    rd_op(mk(4, 5, 1), 4, 0, "R5", lat);
    rd_op(mk(0, 5, 3), 0, 0, "R5", lat);
    rd_op(mk(2, 5, 3), 0, 0, "R5", lat);
    rd_op(mk(3, 5, 3), 0, 0, "R5", lat);
    rd_op(mk(4, 5, 3), 0, 0, "R5", lat);
    rd_op(mk(1, 5, 0), 4, 0, "R5", lat);
    rd_op(mk(0, 5, 0), 4, 0, "R5", lat);

    // R6 R7 R8 write-back allocate, merge, dirty eviction
    do_inv();
    a = mk(0, 9, 1);
    old = bmem[a[13:2]];
    wr_op(a, 32'hDEAD_BEEF, 4'b0110, 4, 0, "R7");
    chk(bmem[a[13:2]] == old, "R6", "memory untouched by write-back store", bmem[a[13:2]], old);
    wr_op(mk(0, 9, 2), 32'hCAFE_F00D, 4'b1111, 0, 0, "R6");
    rd_op(a, 0, 0, "R7", lat);
    rd_op(mk(0, 9, 2), 0, 0, "R6", lat);
    for (int t = 1; t < 4; t++) rd_op(mk(t, 9, 0), 4, 0, "R8", lat);
    rd_op(mk(4, 9, 0), 4, 4, "R8", lat);
    chk(bmem[a[13:2]] == gold_m[a[13:2]], "R8", "written-back word", bmem[a[13:2]], gold_m[a[13:2]]);
    chk(bmem[mk(0, 9, 2) >> 2] == 32'hCAFE_F00D, "R8", "written-back word", bmem[mk(0, 9, 2) >> 2], 32'hCAFE_F00D);
    rd_op(a, 4, 0, "R8", lat);

    // R6 byte-enable sweep over every set
    do_inv();
    for (int s = 0; s < 64; s++) begin
      a = mk(6, s, s % 4);
      rd_op(a, 4, 0, "R6", lat);
      old = bmem[a[13:2]];
      wr_op(a, 32'(s) * 32'h0101_0101 ^ 32'hA5A5_A5A5, 4'((s % 15) + 1), 0, 0, "R6");
      chk(bmem[a[13:2]] == old, "R6", "memory untouched", bmem[a[13:2]], old);
      rd_op(a, 0, 0, "R6", lat);
    end

    // R12 invalidate drops dirty lines; request waits through the sweep
    @(negedge clk); inv = 1'b1;
    @(negedge clk); inv = 1'b0;
    for (int i = 0; i < 4096; i++) gold_m[i] = bmem[i];
    rd_op(mk(6, 3, 3), 4, 0, "R12", lat);
    chk(lat >= 64, "R12", "ready held low during invalidate", 32'(lat), 64);
    rd_op(mk(6, 17, 1), 4, 0, "R12", lat);

    // R9 R10 R11 write-through
    do_inv();
    wb_mode = 1'b0;
    rd_op(mk(0, 12, 0), 4, 0, "R9", lat);
    a = mk(0, 12, 3);
    wr_op(a, 32'h1357_9BDF, 4'b1111, 0, 1, "R9");
    chk(bmem[a[13:2]] == 32'h1357_9BDF, "R9", "memory updated", bmem[a[13:2]], 32'h1357_9BDF);
    rd_op(a, 0, 0, "R9", lat);
    a = mk(1, 12, 0);
    wr_op(a, 32'h0000_AB00, 4'b0010, 0, 1, "R10");
    chk(bmem[a[13:2]] == gold_m[a[13:2]], "R9", "byte-enabled memory write", bmem[a[13:2]], gold_m[a[13:2]]);
    rd_op(a, 4, 0, "R10", lat);
    rd_op(mk(2, 12, 0), 4, 0, "R11", lat);
    rd_op(mk(3, 12, 0), 4, 0, "R11", lat);
    rd_op(mk(4, 12, 0), 4, 0, "R11", lat);
    rd_op(mk(0, 12, 3), 4, 0, "R11", lat);

    finish_run();
  end
endmodule